// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from one idle-high input line. Its clock runs at a fixed multiple of the bit rate: sixteen by default. The line first passes through a short synchronizer chain. The receiver then waits for a high-to-low transition that marks a start bit. It counts half a bit period to reach the middle of that start bit, and from there it samples once per bit period. Each character carries eight data bits, least significant first, then an optional parity bit, then one or two stop bits.

Each finished character is placed in an output register and flagged with `out_valid`. The downstream side accepts it with `out_ready`. The register stays loaded until it is accepted, so back-pressure is absorbed by one character of storage. If a second character finishes before the first is accepted, the new one replaces the old one and the overrun flag is raised. The serial line itself cannot be stalled. The framing and parity flags describe the character currently presented. They are meaningful only while `out_valid` is high.

The configuration inputs select parity on or off, odd or even parity, and one or two stop bits. They must be held steady while a character is being received.

Top module: `async_rx`

## Requirements
- R1: After reset `out_valid`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: A character is delivered on `out_data` with `out_valid` = 1. The first data bit on the line becomes `out_data[0]`.
- R3: `out_valid` stays 1 and `out_data` stays unchanged until a cycle with `out_valid` = 1 and `out_ready` = 1. After that cycle `out_valid` is 0, unless a new character completes.
- R4: With `cfg_parity_en` = 1, a parity bit follows the data bits. With `cfg_parity_odd` = 0 the data bits plus the parity bit must hold an even number of ones. With `cfg_parity_odd` = 1 they must hold an odd number. A mismatch sets `err_parity` with that character. With `cfg_parity_en` = 0 no parity bit is expected and `err_parity` stays 0.
- R5: A stop bit that is sampled low at its centre sets `err_frame` with that character. The data bits are still delivered.
- R6: A falling edge of the line between the last data or parity sample and the final stop sample sets `err_frame`, even when the stop sample itself reads high.
- R7: With `cfg_two_stop` = 1, two stop bits are checked. A low second stop bit sets `err_frame`.
- R8: If the line is high again at the centre of the start bit, no character is delivered and the receiver waits for a new falling edge.
- R9: When a character completes while `out_valid` = 1 and `out_ready` = 0, the new character replaces the old one and `err_overrun` becomes 1. `err_overrun` returns to 0 on the next accepted handshake.
- R10: A line that stays low after a character finishes starts no new character. Only a fresh high-to-low transition starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at OVS times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| cfg_parity_en | input | 1 | 1: a parity bit follows the data |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| out_data | output | DATA_W | Received character |
| out_valid | output | 1 | Character present in the output register |
| out_ready | input | 1 | Downstream accepts the character |
| err_frame | output | 1 | Stop-bit violation for the presented character |
| err_parity | output | 1 | Parity mismatch for the presented character |
| err_overrun | output | 1 | Presented character replaced an unaccepted one |

## Verification
The bench builds the receiver with its default parameters: sixteen clocks per bit, eight data bits and a two-stage synchronizer. Every bit therefore lasts exactly sixteen cycles. This lets the bench place a three-cycle low pulse early in a stop bit, well before its centre sample, and a four-cycle start glitch that has cleared before the half-bit check. With these values, all parity and stop-bit combinations and back-to-back characters for the overrun case fit in a short run.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/async_rx_timer.sv
module async_rx_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic mid_tick,
  output logic full_tick
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] MID_V  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_V = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear)          cnt <= '0;
    else if (cnt == LAST_V)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign mid_tick  = (cnt == MID_V);
  assign full_tick = (cnt == LAST_V);
endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  input  logic              mid_tick,
  input  logic              full_tick,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  output logic              tmr_clear,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int BCW = $clog2(DATA_W + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  rx_state_e         state;
  logic [BCW-1:0]    bit_cnt;
  logic              stop_cnt;
  logic [DATA_W-1:0] shreg;
  logic              par_bad;
  logic              ferr_acc;

  assign tmr_clear = (state == ST_IDLE) || ((state == ST_START) && mid_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      stop_cnt <= 1'b0;
      shreg    <= '0;
      par_bad  <= 1'b0;
      ferr_acc <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          bit_cnt  <= '0;
          stop_cnt <= 1'b0;
          par_bad  <= 1'b0;
          ferr_acc <= 1'b0;
          if (fall) state <= ST_START;
        end
        ST_START: begin
          if (mid_tick) state <= line ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (full_tick) begin
            shreg <= {line, shreg[DATA_W-1:1]};
            if (bit_cnt == LAST_BIT) state <= cfg_parity_en ? ST_PAR : ST_STOP;
            else bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (full_tick) begin
            par_bad <= ((^shreg) ^ line) != cfg_parity_odd;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (full_tick) begin
            if (cfg_two_stop && !stop_cnt) begin
              stop_cnt <= 1'b1;
              ferr_acc <= ferr_acc | fall | ~line;
            end else begin
              done  <= 1'b1;
              data  <= shreg;
              perr  <= par_bad;
              ferr  <= ferr_acc | fall | ~line;
              state <= ST_IDLE;
            end
          end else if (fall) begin
            ferr_acc <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_outreg.sv
module async_rx_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              perr,
  input  logic              ferr,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic accept;
  assign accept = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data    <= '0;
      out_valid   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done) begin
      out_data    <= data;
      out_valid   <= 1'b1;
      err_frame   <= ferr;
      err_parity  <= perr;
      err_overrun <= out_valid & ~out_ready;
    end else if (accept) begin
      out_valid   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic              line_s;
  logic              line_fall;
  logic              tmr_clear;
  logic              mid_tick;
  logic              full_tick;
  logic              rx_done;
  logic [DATA_W-1:0] rx_data;
  logic              rx_perr;
  logic              rx_ferr;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s),
    .fall (line_fall)
  );

  async_rx_timer #(.OVS(OVS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tmr_clear),
    .mid_tick (mid_tick),
    .full_tick(full_tick)
  );

  async_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .line          (line_s),
    .fall          (line_fall),
    .mid_tick      (mid_tick),
    .full_tick     (full_tick),
    .cfg_parity_en (cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop  (cfg_two_stop),
    .tmr_clear     (tmr_clear),
    .done          (rx_done),
    .data          (rx_data),
    .perr          (rx_perr),
    .ferr          (rx_ferr)
  );

  async_rx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (rx_done),
    .data       (rx_data),
    .perr       (rx_perr),
    .ferr       (rx_ferr),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_overrun(err_overrun)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_done,
  input logic              cfg_parity_en,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              err_frame,
  input logic              err_parity,
  input logic              err_overrun
);
  assert_valid_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !rx_done |=> $stable(out_data));

  assert_valid_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !rx_done |=> !out_valid);

  assert_overrun_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> out_valid);

  assert_overrun_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !rx_done |=> !err_overrun);

  assert_flags_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity) |-> out_valid);

  assert_parity_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !cfg_parity_en |=> !err_parity);
endmodule

bind async_rx async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_done      (rx_done),
  .cfg_parity_en(cfg_parity_en),
  .out_data     (out_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .err_frame    (err_frame),
  .err_parity   (err_parity),
  .err_overrun  (err_overrun)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int OVS = 16;
  localparam int NV  = 8;
  // fields: data[14:7] pen[6] podd[5] two[4] badpar[3] badstop1[2] badstop2[1]
  localparam logic [14:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       err_frame;
  logic       err_parity;
  logic       err_overrun;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                      input logic two, input logic badpar, input logic bs1,
                      input logic bs2, input logic stop_glitch);
    cfg_parity_en  = pen;
    cfg_parity_odd = podd;
    cfg_two_stop   = two;
    hold(1'b0, OVS);
    for (int i = 0; i < 8; i++) hold(d[i], OVS);
    if (pen) hold((^d) ^ podd ^ badpar, OVS);
    if (stop_glitch) begin
      hold(1'b1, 2);
      hold(1'b0, 3);
      hold(1'b1, OVS - 5);
    end else begin
      hold(~bs1, OVS);
    end
    if (two) hold(~bs2, OVS);
    hold(1'b1, OVS);
  endtask

  task automatic ack();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", out_valid, 0);
    chk("R1 frame", err_frame, 0);
    chk("R1 parity", err_parity, 0);
    chk("R1 overrun", err_overrun, 0);
    hold(1'b1, 2 * OVS);

    // table of frames: R2 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic pen, podd, two, bp, b1, b2;
      {d, pen, podd, two, bp, b1, b2} = VEC[v][14:1];
      send(d, pen, podd, two, bp, b1, b2, 1'b0);
      chk("R2 valid", out_valid, 1);
      chk("R2 data", out_data, d);
      chk("R4 parity flag", err_parity, pen & bp);
      chk("R5 R7 frame flag", err_frame, b1 | (two & b2));
      chk("R9 no overrun", err_overrun, 0);
      ack();
      chk("R3 valid after accept", out_valid, 0);
    end

    // R6: short low pulse inside the stop bit, stop centre high
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 valid", out_valid, 1);
    chk("R6 data", out_data, 8'hC3);
    chk("R6 frame flag", err_frame, 1);
    ack();

    // R8: start glitch shorter than half a bit
    hold(1'b0, 4);
    hold(1'b1, 4 * OVS);
    chk("R8 no character", out_valid, 0);
    send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 next character", out_data, 8'h96);
    chk("R8 next valid", out_valid, 1);

    // R3: hold without accept
    hold(1'b1, 3 * OVS);
    chk("R3 valid held", out_valid, 1);
    chk("R3 data held", out_data, 8'h96);

    // R9: second character while first unaccepted
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 valid", out_valid, 1);
    chk("R9 data replaced", out_data, 8'h5A);
    chk("R9 overrun set", err_overrun, 1);
    ack();
    chk("R9 overrun cleared", err_overrun, 0);
    chk("R9 valid cleared", out_valid, 0);

    // R10: break, line held low
    cfg_parity_en = 1'b0;
    cfg_two_stop  = 1'b0;
    hold(1'b0, 12 * OVS);
    chk("R10 break character", out_valid, 1);
    chk("R10 break data", out_data, 8'h00);
    chk("R10 break frame flag", err_frame, 1);
    ack();
    hold(1'b0, 20 * OVS);
    chk("R10 no restart while low", out_valid, 0);
    hold(1'b1, 4 * OVS);
    chk("R10 no character after release", out_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule